// File: doc/BRIEF.md
# Data Register Byte Merge Unit

This block sits between a 32-bit data register and the byte-wide transmit and receive FIFOs of a serial controller. A format bit selects how each data access moves bytes. In merged mode, one register write loads four bytes into the transmit FIFO and one read drains four bytes from the receive FIFO, packed little-endian. In single-byte mode, each access moves only the low byte.

The block also provides the format, control, status and configuration registers that software uses for this path. The status flags take the current mode into account, so that a "not full" or "not empty" poll always means the next access of the current width will succeed. The control register holds three self-clearing reset requests, one each for the serial engine, the receive FIFO and the transmit FIFO. The serial engine itself, which pops transmit bytes and pushes received bytes, is outside this block.

Top module: `byte_merge_unit`

## Requirements
- R1: After reset the registers read as follows. reg_sel_i selects the register: 0 format, 1 control, 2 data, 3 status, 4 config. Format reads 0x0000_0700, with the unit-length field [12:8] = 7 (8-bit units) and merge bit 7 clear. Control reads 0. Status reads 0x0000_4000. Config reads {TX code in [7:4], RX code in [3:0]}, where each code is log2(depth)-1.
- R2: With merging off, a data write pushes only bits [7:0] into the TX FIFO. The serial side receives bytes in the order they were written.
- R3: Merging is active when format bit 7 is set and field [12:8] equals 7. In that mode, one data write pushes four bytes, and bits [7:0] leave first, then [15:8], [23:16] and [31:24].
- R4: A merged write is accepted only when the TX FIFO has at least four free entries. Otherwise the whole word is dropped. In merged mode, status bit 23 is set whenever fewer than four entries are free.
- R5: In single-byte mode, status bit 23 is set when the TX FIFO is full, and a data write made while it is full is dropped.
- R6: A single-byte data read pops the oldest RX byte into [7:0] and returns zero in [31:8]. Status bit 14 is set when the RX FIFO is empty. A read while empty returns zero and pops nothing. A serial byte that arrives while the RX FIFO is full is dropped, and rx_space_o is low while it is full.
- R7: A merged data read needs at least four RX bytes and returns the oldest byte in [7:0]. In merged mode, status bit 14 is set while fewer than four bytes are held. A read in that state returns zero and pops nothing.
- R8: Control bit 2 empties the TX FIFO and control bit 1 empties the RX FIFO. Each bit reads as set for one cycle after it is written and then clears itself.
- R9: Control bit 0 raises eng_rst_o. The bit holds until eng_rst_done_i is seen high, then clears.
- R10: With bit 7 set and field [12:8] not equal to 7, data accesses behave as single-byte. A format read returns only bit 7 and bits [12:8]; all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a data read pops at the clock edge) |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the select input |
| tx_pop_i | input | 1 | Serial side takes one TX byte |
| tx_byte_o | output | 8 | Oldest TX byte |
| tx_avail_o | output | 1 | TX FIFO holds at least one byte |
| rx_push_i | input | 1 | Serial side delivers one RX byte |
| rx_byte_i | input | 8 | Received byte |
| rx_space_o | output | 1 | RX FIFO can take a byte |
| eng_rst_o | output | 1 | Serial engine reset request |
| eng_rst_done_i | input | 1 | Serial engine reset finished |

## Verification
A wrong lane pointer or byte count shows up within one access. The bytes leaving the serial side come out rotated or repeated, or a merged read returns a word whose lanes are out of order. A flag computed for the wrong access width shows up in the status read taken just before the FIFO crosses the four-entry margin: it reads ready while a merged word is dropped or a read returns zero. Reset bits that fail to clear are visible on the second control read after the write. A FIFO that fails to empty shows up on tx_avail_o in the next cycle.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [2:0] {
    SEL_FMT  = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_DATA = 3'd2,
    SEL_STAT = 3'd3,
    SEL_CFG  = 3'd4
  } reg_sel_e;

  localparam int unsigned FMT_MERGE_BIT   = 7;
  localparam int unsigned FMT_LEN_LSB     = 8;
  localparam int unsigned STAT_TX_FULL    = 23;
  localparam int unsigned STAT_RX_EMPTY   = 14;
  localparam logic [4:0]  LEN_BYTE_UNIT   = 5'd7;
endpackage

// File: rtl/bmu_byte_fifo.sv
module bmu_byte_fifo #(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned PUSH_LANES = 4,
  parameter int unsigned POP_LANES  = 1,
  localparam int unsigned AW  = $clog2(DEPTH),
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned PNW = $clog2(PUSH_LANES + 1),
  localparam int unsigned QNW = $clog2(POP_LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [PNW-1:0]          push_n_i,
  input  logic [PUSH_LANES*8-1:0] push_data_i,
  input  logic [QNW-1:0]          pop_n_i,
  output logic [POP_LANES*8-1:0]  pop_data_o,
  output logic [CW-1:0]           count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, free;
  logic          push_ok, pop_ok;
  logic [PNW-1:0] push_eff;
  logic [QNW-1:0] pop_eff;

  assign free     = CW'(DEPTH) - count_q;
  assign push_ok  = (push_n_i != '0) && (free >= CW'(push_n_i));
  assign pop_ok   = (pop_n_i != '0) && (count_q >= CW'(pop_n_i));
  assign push_eff = push_ok ? push_n_i : '0;
  assign pop_eff  = pop_ok ? pop_n_i : '0;
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(push_eff);
      rd_ptr_q <= rd_ptr_q + AW'(pop_eff);
      count_q  <= count_q + CW'(push_eff) - CW'(pop_eff);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) begin
      for (int i = 0; i < int'(PUSH_LANES); i++) begin
        if (i < int'(push_n_i)) mem_q[wr_ptr_q + AW'(i)] <= push_data_i[i*8 +: 8];
      end
    end
  end

  for (genvar g = 0; g < int'(POP_LANES); g++) begin : g_pop_lane
    assign pop_data_o[g*8 +: 8] = mem_q[rd_ptr_q + AW'(g)];
  end

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_q == '0); // R8
endmodule

// File: rtl/bmu_regs.sv
module bmu_regs
  import bmu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_fmt_i,
  input  logic       wr_ctrl_i,
  input  logic       merge_bit_i,
  input  logic [4:0] unit_len_i,
  input  logic [2:0] ctrl_bits_i,
  input  logic       eng_done_i,
  output logic [31:0] fmt_o,
  output logic [2:0]  ctrl_o,
  output logic        merge_o
);
  logic       merge_q;
  logic [4:0] len_q;
  logic [2:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      merge_q <= 1'b0;
      len_q   <= LEN_BYTE_UNIT;
    end else if (wr_fmt_i) begin
      merge_q <= merge_bit_i;
      len_q   <= unit_len_i;
    end
  end

  // FIFO reset bits live one cycle; engine reset waits for the done handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q[2:1] <= wr_ctrl_i ? ctrl_bits_i[2:1] : 2'b00;
      if (wr_ctrl_i && ctrl_bits_i[0]) ctrl_q[0] <= 1'b1;
      else if (eng_done_i)             ctrl_q[0] <= 1'b0;
    end
  end

  always_comb begin
    fmt_o = '0;
    fmt_o[FMT_MERGE_BIT] = merge_q;
    fmt_o[FMT_LEN_LSB +: 5] = len_q;
  end
  assign ctrl_o  = ctrl_q;
  assign merge_o = merge_q && (len_q == LEN_BYTE_UNIT);

  AST_FIFO_RST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[2] && !(wr_ctrl_i && ctrl_bits_i[2])) |=> !ctrl_q[2]); // R8
  AST_ENG_RST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[0] && !eng_done_i) |=> ctrl_q[0]); // R9
endmodule

// File: rtl/byte_merge_unit.sv
module byte_merge_unit
  import bmu_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_byte_o,
  output logic        tx_avail_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_byte_i,
  output logic        rx_space_o,
  output logic        eng_rst_o,
  input  logic        eng_rst_done_i
);
  localparam int unsigned TCW = $clog2(TX_DEPTH + 1);
  localparam int unsigned RCW = $clog2(RX_DEPTH + 1);
  localparam int unsigned NW  = $clog2(LANES + 1);
  localparam logic [3:0] TX_CODE = 4'($clog2(TX_DEPTH) - 1);
  localparam logic [3:0] RX_CODE = 4'($clog2(RX_DEPTH) - 1);

  logic [31:0]    fmt_word;
  logic [2:0]     ctrl_q;
  logic           merge;
  logic [NW-1:0]  step;
  logic [TCW-1:0] tx_count;
  logic [RCW-1:0] rx_count;
  logic           tx_full_flag, rx_empty_flag;
  logic           data_wr, data_rd;
  logic [NW-1:0]  tx_push_n, rx_pop_n;
  logic [31:0]    tx_push_data, rx_pop_data, rd_word, stat_word;

  bmu_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_fmt_i    (reg_wr_i && reg_sel_i == SEL_FMT),
    .wr_ctrl_i   (reg_wr_i && reg_sel_i == SEL_CTRL),
    .merge_bit_i (reg_wdata_i[FMT_MERGE_BIT]),
    .unit_len_i  (reg_wdata_i[FMT_LEN_LSB +: 5]),
    .ctrl_bits_i (reg_wdata_i[2:0]),
    .eng_done_i  (eng_rst_done_i),
    .fmt_o       (fmt_word),
    .ctrl_o      (ctrl_q),
    .merge_o     (merge)
  );

  assign step    = merge ? NW'(LANES) : NW'(1);
  assign data_wr = reg_wr_i && reg_sel_i == SEL_DATA;
  assign data_rd = reg_rd_i && reg_sel_i == SEL_DATA;

  // flags reflect the width of the next access, not raw occupancy
  assign tx_full_flag  = (TCW'(TX_DEPTH) - tx_count) < TCW'(step);
  assign rx_empty_flag = rx_count < RCW'(step);

  assign tx_push_n    = (data_wr && !tx_full_flag) ? step : '0;
  assign tx_push_data = merge ? reg_wdata_i : {24'h0, reg_wdata_i[7:0]};
  assign rx_pop_n     = (data_rd && !rx_empty_flag) ? step : '0;

  bmu_byte_fifo #(.DEPTH(TX_DEPTH), .PUSH_LANES(LANES), .POP_LANES(1)) i_tx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (ctrl_q[2]),
    .push_n_i    (tx_push_n),
    .push_data_i (tx_push_data),
    .pop_n_i     (tx_pop_i),
    .pop_data_o  (tx_byte_o),
    .count_o     (tx_count)
  );

  bmu_byte_fifo #(.DEPTH(RX_DEPTH), .PUSH_LANES(1), .POP_LANES(LANES)) i_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (ctrl_q[1]),
    .push_n_i    (rx_push_i),
    .push_data_i (rx_byte_i),
    .pop_n_i     (rx_pop_n),
    .pop_data_o  (rx_pop_data),
    .count_o     (rx_count)
  );

  assign tx_avail_o = tx_count != '0;
  assign rx_space_o = rx_count != RCW'(RX_DEPTH);
  assign eng_rst_o  = ctrl_q[0];

  assign rd_word = rx_empty_flag ? 32'h0 :
                   merge ? rx_pop_data : {24'h0, rx_pop_data[7:0]};

  always_comb begin
    stat_word = '0;
    stat_word[STAT_TX_FULL]  = tx_full_flag;
    stat_word[STAT_RX_EMPTY] = rx_empty_flag;
  end

  always_comb begin
    case (reg_sel_i)
      SEL_FMT:  reg_rdata_o = fmt_word;
      SEL_CTRL: reg_rdata_o = {29'h0, ctrl_q};
      SEL_DATA: reg_rdata_o = rd_word;
      SEL_STAT: reg_rdata_o = stat_word;
      SEL_CFG:  reg_rdata_o = {24'h0, TX_CODE, RX_CODE};
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_MERGED_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && merge && tx_full_flag && !ctrl_q[2]) |=> tx_count <= $past(tx_count)); // R4
  AST_SINGLE_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !merge) |-> reg_rdata_o[31:8] == 24'h0); // R6
  AST_EMPTY_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && rx_empty_flag) |=> rx_count >= $past(rx_count)); // R7
endmodule

// File: tb/test_byte_merge_unit.sv
`timescale 1ns/1ps
module test_byte_merge_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tx_pop_i = 1'b0;
  logic [7:0]  tx_byte_o;
  logic        tx_avail_o;
  logic        rx_push_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        rx_space_o;
  logic        eng_rst_o;
  logic        eng_rst_done_i = 1'b0;

  localparam logic [2:0] S_FMT = 0, S_CTRL = 1, S_DATA = 2, S_STAT = 3, S_CFG = 4;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] tx_q[$];

  always #4 clk_i = ~clk_i;

  byte_merge_unit i_byte_merge_unit (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk_i);
    reg_sel_i = s; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(posedge clk_i); #1 reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk_i);
    reg_sel_i = s; reg_rd_i = 1'b1;
    #1 v = reg_rdata_o;
    @(posedge clk_i); #1 reg_rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] s, input logic [31:0] exp);
    logic [31:0] v;
    rd(s, v);
    check(req, v, exp);
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk_i);
    rx_byte_i = b; rx_push_i = 1'b1;
    @(posedge clk_i); #1 rx_push_i = 1'b0;
  endtask

  // monitor side of the scoreboard: pop serial bytes and compare with queue
  task automatic drain(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] exp;
      @(negedge clk_i);
      #1;
      check({req, " avail"}, {31'h0, tx_avail_o}, 32'h1);
      exp = (tx_q.size() != 0) ? tx_q.pop_front() : 8'h00;
      check({req, " byte"}, {24'h0, tx_byte_o}, {24'h0, exp});
      tx_pop_i = 1'b1;
      @(posedge clk_i); #1 tx_pop_i = 1'b0;
    end
  endtask

  task automatic tx_idle(input string req);
    @(negedge clk_i); #1;
    check(req, {31'h0, tx_avail_o}, 32'h0);
  endtask

  // driver side: write a data word and record the bytes it should deliver
  task automatic drive_word(input logic [31:0] d, input int nbytes);
    wr(S_DATA, d);
    for (int i = 0; i < nbytes; i++) tx_q.push_back(d[i*8 +: 8]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1 fmt", S_FMT, 32'h0000_0700);
    rd_chk("R1 ctrl", S_CTRL, 32'h0);
    rd_chk("R1 stat", S_STAT, 32'h0000_4000);
    rd_chk("R1 cfg", S_CFG, 32'h0000_0023);
    tx_idle("R1 tx empty");

    // R2 single byte writes use low byte only
    drive_word(32'hAABB_CC11, 1);
    drive_word(32'h0000_0022, 1);
    drive_word(32'hFFFF_FF33, 1);
    drain("R2", 3);
    tx_idle("R2 no extra bytes");

    // R3 merged writes, little-endian order
    wr(S_FMT, 32'h0000_0780);
    drive_word(32'h4433_2211, 4);
    drive_word(32'h8877_6655, 4);
    drain("R3", 8);
    tx_idle("R3 no extra bytes");

    // R4 merged room rule
    drive_word(32'hA3A2_A1A0, 4);
    drive_word(32'hB3B2_B1B0, 4);
    rd_chk("R4 stat full", S_STAT, 32'h0080_4000);
    wr(S_DATA, 32'hC3C2_C1C0);              // dropped
    drain("R4 partial", 3);
    rd_chk("R4 stat free3", S_STAT, 32'h0080_4000);
    drain("R4 partial", 1);
    rd_chk("R4 stat free4", S_STAT, 32'h0000_4000);
    drive_word(32'hD3D2_D1D0, 4);
    drain("R4 order", 8);
    tx_idle("R4 dropped word absent");

    // R5 single byte full
    wr(S_FMT, 32'h0000_0700);
    for (int i = 0; i < 8; i++) drive_word(32'h10 + i, 1);
    rd_chk("R5 stat full", S_STAT, 32'h0080_4000);
    wr(S_DATA, 32'h0000_0018);              // dropped
    drain("R5", 8);
    tx_idle("R5 dropped byte absent");

    // R6 single byte reads
    push_rx(8'h5A);
    push_rx(8'h6B);
    rd_chk("R6 stat", S_STAT, 32'h0);
    rd_chk("R6 rd0", S_DATA, 32'h0000_005A);
    rd_chk("R6 rd1", S_DATA, 32'h0000_006B);
    rd_chk("R6 stat empty", S_STAT, 32'h0000_4000);
    rd_chk("R6 rd empty", S_DATA, 32'h0);
    for (int i = 0; i < 16; i++) push_rx(8'h80 + 8'(i));
    @(negedge clk_i); #1;
    check("R6 rx_space full", {31'h0, rx_space_o}, 32'h0);
    push_rx(8'hEE);                          // dropped
    for (int i = 0; i < 16; i++) rd_chk("R6 rx order", S_DATA, 32'h80 + i);
    rd_chk("R6 overflow dropped", S_DATA, 32'h0);

    // R7 merged reads
    wr(S_FMT, 32'h0000_0780);
    push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
    rd_chk("R7 stat three", S_STAT, 32'h0000_4000);
    rd_chk("R7 short rd", S_DATA, 32'h0);
    push_rx(8'h04);
    rd_chk("R7 stat four", S_STAT, 32'h0);
    rd_chk("R7 word", S_DATA, 32'h0403_0201);
    rd_chk("R7 stat after", S_STAT, 32'h0000_4000);

    // R10 merge bit with other unit length
    wr(S_FMT, 32'hFFFF_FFFF);
    rd_chk("R10 fmt fields", S_FMT, 32'h0000_1F80);
    drive_word(32'h4433_2211, 1);
    drain("R10 single", 1);
    tx_idle("R10 one byte only");

    // R8 FIFO reset bits
    wr(S_FMT, 32'h0000_0700);
    wr(S_DATA, 32'h1); wr(S_DATA, 32'h2); wr(S_DATA, 32'h3);
    wr(S_CTRL, 32'h4);
    rd_chk("R8 tx bit set", S_CTRL, 32'h4);
    rd_chk("R8 tx bit cleared", S_CTRL, 32'h0);
    tx_idle("R8 tx flushed");
    drive_word(32'h77, 1);
    drain("R8 tx after flush", 1);
    push_rx(8'h31); push_rx(8'h32);
    wr(S_CTRL, 32'h2);
    rd_chk("R8 rx bit set", S_CTRL, 32'h2);
    rd_chk("R8 rx bit cleared", S_CTRL, 32'h0);
    rd_chk("R8 rx stat", S_STAT, 32'h0000_4000);
    rd_chk("R8 rx flushed", S_DATA, 32'h0);

    // R9 engine reset handshake
    wr(S_CTRL, 32'h1);
    @(negedge clk_i); #1;
    check("R9 eng_rst raised", {31'h0, eng_rst_o}, 32'h1);
    repeat (5) @(negedge clk_i);
    rd_chk("R9 bit held", S_CTRL, 32'h1);
    @(negedge clk_i); #1;
    check("R9 eng_rst held", {31'h0, eng_rst_o}, 32'h1);
    eng_rst_done_i = 1'b1;
    @(negedge clk_i); #1;
    eng_rst_done_i = 1'b0;
    check("R9 eng_rst cleared", {31'h0, eng_rst_o}, 32'h0);
    rd_chk("R9 bit cleared", S_CTRL, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule